// File: doc/BRIEF.md
# Interrupt Destination Filter

This block decides whether an incoming interrupt message is addressed to the local interrupt controller. It holds three configuration values: an 8-bit physical identifier, an 8-bit logical identifier, and a logical addressing format. The format is either a flat bitmask or a cluster format that splits the logical identifier into a group nibble and a member nibble. Each message carries an addressing mode (physical or logical), an 8-bit destination, a 2-bit shorthand code and a flag that is set when the local unit sent the message itself.

Messages arrive on a valid/ready stream. `msg_ready` is held high at all times, so the filter never applies back-pressure and every cycle with `msg_valid` high is a handshake. One clock after each handshake the filter presents a one-cycle result (`res_valid` together with `res_accept`). A running count of accepted messages is kept on `acc_count`. Configuration is written through a plain word-wide write port.

Top module: `irq_dest_filter`

## Requirements
- R1: In logical mode with the flat format (format bit 0), a message with shorthand 2'b00 is accepted when the bitwise AND of its destination and the logical identifier is nonzero. Destination bits that do not belong to this unit do not prevent acceptance.
- R2: In logical mode with the cluster format (format bit 1), a message with shorthand 2'b00 is accepted only when destination bits 7:4 equal logical identifier bits 7:4 and destination bits 3:0 overlap logical identifier bits 3:0.
- R3: A message with shorthand 2'b00 and destination 8'hFF is accepted in both modes and both formats, whatever the identifiers hold.
- R4: In physical mode (`msg_logical` = 0) with shorthand 2'b00, a message is accepted exactly when its destination equals the physical identifier. Units that share an identifier each accept it.
- R5: Shorthand 2'b10 (everyone) is always accepted. Shorthand 2'b01 (self) is accepted only when `msg_from_self` is 1. Shorthand 2'b11 (everyone but the sender) is accepted only when `msg_from_self` is 0. In all three cases the destination and mode are ignored.
- R6: A logical identifier of 8'h00 matches no logical-mode message except the broadcast destination 8'hFF.
- R7: A write with `cfg_sel` 2'd0 loads the physical identifier from `cfg_wdata[31:24]`. A write with `cfg_sel` 2'd1 loads the logical identifier from `cfg_wdata[31:24]`. A write with `cfg_sel` 2'd2 loads the format from `cfg_wdata[0]`. The new value applies to messages handshaken in later cycles.
- R8: `res_valid` is high in exactly the cycle after each handshake. `res_accept` is high only with `res_valid`, and it carries the decision for that message.
- R9: `acc_count` increases by one in the cycle `res_accept` is high, holds otherwise, and wraps modulo 2^CNT_W.
- R10: After reset, both identifiers are 8'h00, the format is flat, `res_valid`, `res_accept` and `acc_count` are 0, and `msg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 physical ID, 1 logical ID, 2 format |
| cfg_wdata | input | 32 | Configuration write word |
| msg_valid | input | 1 | Message valid |
| msg_ready | output | 1 | Message ready, always 1 |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_dest | input | 8 | Destination field |
| msg_short | input | 2 | Shorthand code |
| msg_from_self | input | 1 | Message was sent by this unit |
| res_valid | output | 1 | Result strobe, one cycle after handshake |
| res_accept | output | 1 | Message addressed to this unit |
| acc_count | output | CNT_W | Count of accepted messages, wrapping |

## Verification
The bound properties take for granted that `cfg_we` is never raised in the same cycle as a message whose outcome they predict. They also assume `msg_from_self` is meaningful only when the shorthand is self or everyone-but-sender. The stimulus keeps configuration writes and messages in separate cycles. It draws shorthands, modes and destinations at random, with destinations biased toward the configured identifiers so that both hits and misses occur. Directed cases cover a zero logical identifier, cluster group mismatches, broadcast under each format, and counter wrap with a narrow counter.

// File: rtl/irq_dest_filter_pkg.sv
package irq_dest_filter_pkg;
  localparam int ID_W = 8;
  localparam int GRP_W = ID_W / 2;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_SELF = 2'b01,
    SH_ALL  = 2'b10,
    SH_OTHR = 2'b11
  } shorthand_e;

  typedef enum logic {
    FMT_FLAT    = 1'b0,
    FMT_CLUSTER = 1'b1
  } lfmt_e;

  typedef enum logic [1:0] {
    SEL_PHYS = 2'd0,
    SEL_LOG  = 2'd1,
    SEL_FMT  = 2'd2
  } cfg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0] phys_id;
    logic [ID_W-1:0] log_id;
    lfmt_e           fmt;
  } filt_cfg_t;
endpackage

// File: rtl/idf_cfg_regs.sv
module idf_cfg_regs
  import irq_dest_filter_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output filt_cfg_t         cfg
);
  localparam int ID_LSB = WORD_W - ID_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.phys_id <= '0;
      cfg.log_id  <= '0;
      cfg.fmt     <= FMT_FLAT;
    end else if (we) begin
      unique case (cfg_sel_e'(sel))
        SEL_PHYS: cfg.phys_id <= wdata[WORD_W-1:ID_LSB];
        SEL_LOG:  cfg.log_id  <= wdata[WORD_W-1:ID_LSB];
        SEL_FMT:  cfg.fmt     <= lfmt_e'(wdata[0]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/idf_decide.sv
module idf_decide
  import irq_dest_filter_pkg::*;
(
  input  filt_cfg_t        cfg,
  input  logic             logical,
  input  logic [ID_W-1:0]  dest,
  input  logic [1:0]       short,
  input  logic             from_self,
  output logic             hit
);
  logic bcast, flat_hit, grp_eq, mem_hit, log_hit, phys_hit;

  always_comb begin
    bcast    = &dest;
    flat_hit = |(dest & cfg.log_id);
    grp_eq   = dest[ID_W-1:GRP_W] == cfg.log_id[ID_W-1:GRP_W];
    mem_hit  = |(dest[GRP_W-1:0] & cfg.log_id[GRP_W-1:0]);
    log_hit  = (cfg.fmt == FMT_CLUSTER) ? (grp_eq && mem_hit) : flat_hit;
    phys_hit = dest == cfg.phys_id;
    unique case (shorthand_e'(short))
      SH_SELF: hit = from_self;
      SH_ALL:  hit = 1'b1;
      SH_OTHR: hit = !from_self;
      default: hit = bcast || (logical ? log_hit : phys_hit);
    endcase
  end
endmodule

// File: rtl/idf_result.sv
module idf_result #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             hit,
  output logic             res_valid,
  output logic             res_accept,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      count      <= '0;
    end else begin
      res_valid  <= take;
      res_accept <= take && hit;
      if (take && hit) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter
  import irq_dest_filter_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic              msg_logical,
  input  logic [7:0]        msg_dest,
  input  logic [1:0]        msg_short,
  input  logic              msg_from_self,
  output logic              res_valid,
  output logic              res_accept,
  output logic [CNT_W-1:0]  acc_count
);
  filt_cfg_t cfg;
  logic      hit;

  assign msg_ready = 1'b1;

  idf_cfg_regs #(.WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  idf_decide u_dec (
    .cfg(cfg), .logical(msg_logical), .dest(msg_dest),
    .short(msg_short), .from_self(msg_from_self), .hit(hit)
  );

  idf_result #(.CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .take(msg_valid && msg_ready), .hit(hit),
    .res_valid(res_valid), .res_accept(res_accept), .count(acc_count)
  );
endmodule

// File: rtl/irq_dest_filter_chk.sv
module irq_dest_filter_chk #(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic              msg_logical,
  input logic [7:0]        msg_dest,
  input logic [1:0]        msg_short,
  input logic              msg_from_self,
  input logic              res_valid,
  input logic              res_accept,
  input logic [CNT_W-1:0]  acc_count
);
  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> res_valid);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !res_valid);
  // R8
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);
  // R5
  all_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b10) |=> res_accept);
  // R5
  self_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b01) |=> (res_accept == $past(msg_from_self)));
  // R5
  others_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b11) |=> (res_accept == !$past(msg_from_self)));
  // R3
  broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b00 && msg_dest == 8'hFF) |=> res_accept);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> (acc_count == $past(acc_count) + 1'b1));
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_accept |-> $stable(acc_count));
  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready);
endmodule

bind irq_dest_filter irq_dest_filter_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/irq_dest_filter_bench.sv
module irq_dest_filter_bench;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic msg_valid = 1'b0;
  logic msg_ready;
  logic msg_logical = 1'b0;
  logic [7:0] msg_dest = '0;
  logic [1:0] msg_short = '0;
  logic msg_from_self = 1'b0;
  logic res_valid, res_accept;
  logic [CNT_W-1:0] acc_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_pid = 8'h00;
  logic [7:0] m_lid = 8'h00;
  bit m_clu = 1'b0;
  logic [CNT_W-1:0] m_cnt = '0;

  always #2 clk = ~clk;

  irq_dest_filter #(.CNT_W(CNT_W)) u_irq_dest_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_logical(msg_logical), .msg_dest(msg_dest), .msg_short(msg_short),
    .msg_from_self(msg_from_self), .res_valid(res_valid),
    .res_accept(res_accept), .acc_count(acc_count)
  );

  function automatic bit model(bit lg, logic [7:0] d, logic [1:0] sh, bit slf);
    if (sh == 2'b01) return slf;
    if (sh == 2'b10) return 1'b1;
    if (sh == 2'b11) return !slf;
    if (d == 8'hFF) return 1'b1;
    if (!lg) return d == m_pid;
    if (m_clu) return (d[7:4] == m_lid[7:4]) && ((d[3:0] & m_lid[3:0]) != 0);
    return (d & m_lid) != 0;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_pid = data[31:24];
    else if (sel == 2'd1) m_lid = data[31:24];
    else if (sel == 2'd2) m_clu = data[0];
  endtask

  task automatic send(string req, bit lg, logic [7:0] d, logic [1:0] sh, bit slf);
    bit exp;
    exp = model(lg, d, sh, slf);
    @(negedge clk);
    msg_valid = 1'b1; msg_logical = lg; msg_dest = d;
    msg_short = sh; msg_from_self = slf;
    @(negedge clk);
    msg_valid = 1'b0;
    if (exp) m_cnt = m_cnt + 1'b1;
    check({req, " valid"}, res_valid, 1);
    check(req, res_accept, exp);
    check({req, " R9 count"}, acc_count, m_cnt);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 res_valid", res_valid, 0);
    check("R10 res_accept", res_accept, 0);
    check("R10 acc_count", acc_count, 0);
    check("R10 msg_ready", msg_ready, 1);
    send("R10 phys id zero", 1'b0, 8'h00, 2'b00, 1'b0);
    send("R10 phys miss", 1'b0, 8'h01, 2'b00, 1'b0);
    // R6 zero logical id
    send("R6 flat zero id", 1'b1, 8'h7F, 2'b00, 1'b0);
    send("R3 broadcast zero id", 1'b1, 8'hFF, 2'b00, 1'b0);
    // R7 + R4 physical
    cfg_write(2'd0, 32'h5A00_0000);
    send("R4 R7 phys hit", 1'b0, 8'h5A, 2'b00, 1'b0);
    send("R4 phys miss", 1'b0, 8'h5B, 2'b00, 1'b0);
    send("R3 phys broadcast", 1'b0, 8'hFF, 2'b00, 1'b0);
    // R1 flat
    cfg_write(2'd1, 32'h0400_0000);
    send("R1 flat overlap", 1'b1, 8'h0C, 2'b00, 1'b0);
    send("R1 flat no overlap", 1'b1, 8'h03, 2'b00, 1'b0);
    // R2 cluster
    cfg_write(2'd1, 32'h3200_0000);
    cfg_write(2'd2, 32'h0000_0001);
    send("R2 cluster hit", 1'b1, 8'h33, 2'b00, 1'b0);
    send("R2 cluster group miss", 1'b1, 8'h42, 2'b00, 1'b0);
    send("R2 cluster member miss", 1'b1, 8'h31, 2'b00, 1'b0);
    send("R3 cluster broadcast", 1'b1, 8'hFF, 2'b00, 1'b0);
    cfg_write(2'd1, 32'h0000_0000);
    send("R6 cluster zero id", 1'b1, 8'h0F, 2'b00, 1'b0);
    // R5 shorthands
    send("R5 self from other", 1'b0, 8'h5A, 2'b01, 1'b0);
    send("R5 self from self", 1'b0, 8'h00, 2'b01, 1'b1);
    send("R5 all", 1'b1, 8'h00, 2'b10, 1'b1);
    send("R5 others from self", 1'b0, 8'h5A, 2'b11, 1'b1);
    send("R5 others from other", 1'b1, 8'h00, 2'b11, 1'b0);
    // R8 gap: idle cycle has no result
    @(negedge clk);
    check("R8 idle", res_valid, 0);
    // random mix, R9 wrap exercised by narrow counter
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 19);
      if (r == 0) cfg_write(2'($urandom_range(0, 2)), $urandom);
      r = $urandom_range(0, 3);
      d = 8'($urandom);
      if (r == 0) d = m_pid;
      else if (r == 1) d = {m_lid[7:4], 4'($urandom)};
      send("R1 R2 R4 R5 random", 1'($urandom), d,
           ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00, 1'($urandom));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule